// File: doc/BRIEF.md
# Auto-Reload Timer with Split Mode

This block is a 16-bit up-counter kept as two byte registers. Each byte has its own byte of a 16-bit reload value. When the count reaches its top value it reloads from that value instead of wrapping to zero. A mode bit picks one of two layouts. In the first, both bytes form one 16-bit counter. In the second, they act as two independent 8-bit counters that share one count tick. The tick comes from one of three sources: every system clock cycle, every twelfth system clock cycle, or every eighth rising edge of an external clock that is synchronised into the system clock domain.

Each wrap sets a sticky overflow flag and sends a one-cycle pulse to neighbouring peripherals. The flags can drive one interrupt request. The high-byte flag always counts toward the request, and the low-byte flag counts only when its own enable bit is set. Software reaches the block through a byte-wide register port. That port has a synchronous write strobe and a combinational read path.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, and `irq`, `ovf_lo_pulse` and `ovf_hi_pulse` are low.
- R2: While the run bit is 1, the count advances by one on every tick. While the run bit is 0, the count holds its value.
- R3: In 16-bit mode (split bit 0), a tick at count 0xFFFF loads the full reload value into the count. The same tick sets the high flag (control bit 7) and raises `ovf_hi_pulse` for one cycle.
- R4: A tick at low byte 0xFF sets the low flag (control bit 6) and raises `ovf_lo_pulse` for one cycle, in either mode. This happens whatever the value of the low-interrupt enable.
- R5: In split mode (split bit 1), both bytes advance on every tick. Each byte at 0xFF reloads its own reload byte and sets its own flag and pulse. In 16-bit mode the low byte reloads only on a 16-bit wrap.
- R6: `irq` is high exactly when the interrupt enable (control bit 3) is 1 and either the high flag is set or the low-interrupt enable (control bit 2) and the low flag are both set.
- R7: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: A bus write to a count byte takes priority over that byte's reload or increment in the same cycle. The other byte still reloads or advances as usual.
- R9: With source select (control bits 5:4) = 1, the tick is every twelfth system clock cycle. A window of 36 cycles therefore advances the count by exactly 3.
- R10: With source select = 2, the tick is every eighth rising edge of `ext_clk`, seen through a two-flop synchroniser. Source select 0 ticks on every cycle, and 3 never ticks.
- R11: Register addresses are as follows. 0 is control: run bit 0, split bit 1, low-interrupt enable bit 2, interrupt enable bit 3, source bits 5:4, flags bits 7:6. Addresses 1 and 2 are the count low and high bytes, 3 and 4 are the reload low and high bytes, and 5 to 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External clock, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request (level) |
| ovf_lo_pulse | output | 1 | One-cycle pulse on a low-byte wrap |
| ovf_hi_pulse | output | 1 | One-cycle pulse on a high-byte or 16-bit wrap |

## Verification
The assertions take for granted that the bus is the only thing that writes to the block. A flag may fall, or a stopped count may change, only in the cycle after a bus write. The reload check is skipped after any write, because software may have overwritten the count or the reload. The assertions also assume `ext_clk` is slow compared with `clk`. The stimulus holds every write to a single cycle and toggles `ext_clk` every three system cycles, away from `clk` edges. It measures the divided sources over windows that are whole multiples of their periods, so the unknown prescaler phase cannot change the result.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int BYTE_W = 8;
    localparam int NBYTES = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_DIV   = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_NONE  = 2'd3
    } tick_src_e;

    typedef struct packed {
        logic      flag_hi;
        logic      flag_lo;
        tick_src_e src;
        logic      irq_en;
        logic      lo_irq_en;
        logic      split;
        logic      run;
    } ctrl_t;

    function automatic logic all_ones(input logic [BYTE_W-1:0] v);
        return &v;
    endfunction
endpackage

// File: rtl/tick_gen.sv
module tick_gen
    import timer_pkg::*;
#(
    parameter int DIV_SYS = 12,
    parameter int DIV_EXT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_clk,
    input  tick_src_e src,
    output logic      tick
);
    localparam int SW = $clog2(DIV_SYS);
    localparam int EW = $clog2(DIV_EXT);

    logic [SW-1:0] pre_q;
    logic          pre_tick;
    logic [2:0]    ext_sh;
    logic          ext_rise;
    logic [EW-1:0] ext_q;
    logic          ext_tick;

    assign pre_tick = (pre_q == SW'(DIV_SYS - 1));

    always_ff @(posedge clk) begin
        if (rst)           pre_q <= '0;
        else if (pre_tick) pre_q <= '0;
        else               pre_q <= pre_q + 1'b1;
    end

    // two synchroniser stages, third flop for edge detection
    always_ff @(posedge clk) begin
        if (rst) ext_sh <= '0;
        else     ext_sh <= {ext_sh[1:0], ext_clk};
    end

    assign ext_rise = ext_sh[1] & ~ext_sh[2];
    assign ext_tick = ext_rise && (ext_q == EW'(DIV_EXT - 1));

    always_ff @(posedge clk) begin
        if (rst)           ext_q <= '0;
        else if (ext_tick) ext_q <= '0;
        else if (ext_rise) ext_q <= ext_q + 1'b1;
    end

    always_comb begin
        case (src)
            SRC_SYS: tick = 1'b1;
            SRC_DIV: tick = pre_tick;
            SRC_EXT: tick = ext_tick;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/count_byte.sv
module count_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    // bus write beats reload, reload beats increment
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (wr)   q <= wr_val;
        else if (load) q <= load_val;
        else if (inc)  q <= q + 1'b1;
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import timer_pkg::*;
#(
    parameter int DIV_SYS = 12,
    parameter int DIV_EXT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_clk,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                irq,
    output logic                ovf_lo_pulse,
    output logic                ovf_hi_pulse
);
    ctrl_t             ctrl_q;
    logic              tick;
    logic              tick_run;
    logic [BYTE_W-1:0] cnt [NBYTES];
    logic [BYTE_W-1:0] rld [NBYTES];
    logic              inc  [NBYTES];
    logic              load [NBYTES];
    logic              full [NBYTES];
    logic              wrap16, lo_wrap, hi_wrap, wr_ctrl;
    logic [2*BYTE_W-1:0] cnt16, rld16;

    tick_gen #(.DIV_SYS(DIV_SYS), .DIV_EXT(DIV_EXT)) u_tick (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .src(ctrl_q.src), .tick(tick)
    );

    assign tick_run = tick & ctrl_q.run;
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic wr_cnt, wr_rld;
        assign full[i] = all_ones(cnt[i]);
        assign wr_cnt  = bus_wr && (bus_addr == A_CNT_LO + ADDR_W'(i));
        assign wr_rld  = bus_wr && (bus_addr == A_RLD_LO + ADDR_W'(i));

        count_byte #(.W(BYTE_W)) u_cnt (
            .clk(clk), .rst(rst),
            .wr(wr_cnt), .wr_val(bus_wdata),
            .load(load[i]), .load_val(rld[i]),
            .inc(inc[i]), .q(cnt[i])
        );

        always_ff @(posedge clk) begin
            if (rst)         rld[i] <= '0;
            else if (wr_rld) rld[i] <= bus_wdata;
        end
    end

    assign wrap16  = tick_run & ~ctrl_q.split & full[0] & full[1];
    assign lo_wrap = tick_run & full[0];
    assign hi_wrap = ctrl_q.split ? (tick_run & full[1]) : wrap16;

    assign inc[0]  = tick_run;
    assign load[0] = ctrl_q.split ? lo_wrap : wrap16;
    assign inc[1]  = ctrl_q.split ? tick_run : (tick_run & full[0]);
    assign load[1] = hi_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            ovf_lo_pulse <= 1'b0;
            ovf_hi_pulse <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.src       <= tick_src_e'(bus_wdata[5:4]);
                ctrl_q.irq_en    <= bus_wdata[3];
                ctrl_q.lo_irq_en <= bus_wdata[2];
                ctrl_q.split     <= bus_wdata[1];
                ctrl_q.run       <= bus_wdata[0];
            end
            ctrl_q.flag_hi <= (ctrl_q.flag_hi & ~(wr_ctrl & bus_wdata[7])) | hi_wrap;
            ctrl_q.flag_lo <= (ctrl_q.flag_lo & ~(wr_ctrl & bus_wdata[6])) | lo_wrap;
            ovf_lo_pulse   <= lo_wrap;
            ovf_hi_pulse   <= hi_wrap;
        end
    end

    assign irq = ctrl_q.irq_en &
                 (ctrl_q.flag_hi | (ctrl_q.lo_irq_en & ctrl_q.flag_lo));

    assign cnt16 = {cnt[1], cnt[0]};
    assign rld16 = {rld[1], rld[0]};

    always_comb begin
        case (bus_addr)
            3'd0:    bus_rdata = ctrl_q;
            3'd1:    bus_rdata = cnt[0];
            3'd2:    bus_rdata = cnt[1];
            3'd3:    bus_rdata = rld[0];
            3'd4:    bus_rdata = rld[1];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/timer_checker.sv
module timer_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        irq,
    input logic        ovf_lo_pulse,
    input logic        ovf_hi_pulse,
    input logic [7:0]  ctrl,
    input logic [15:0] cnt16,
    input logic [15:0] rld16
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt16 == 16'h0) && !irq && !ovf_lo_pulse && !ovf_hi_pulse);

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctrl[0]) && !$past(bus_wr)) |-> $stable(cnt16));

    p_hi_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_hi_pulse && !ctrl[1] && !$past(bus_wr)) |-> (cnt16 == rld16));

    p_lo_pulse_flag_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_lo_pulse |-> ctrl[6]);

    p_hi_pulse_flag_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_hi_pulse |-> ctrl[7]);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl[3] |-> !irq);

    p_flag_hi_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[7]) |-> $past(bus_wr && (bus_addr == 3'd0) && bus_wdata[7]));

    p_flag_lo_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[6]) |-> $past(bus_wr && (bus_addr == 3'd0) && bus_wdata[6]));
endmodule

bind reload_timer timer_checker u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .ovf_lo_pulse(ovf_lo_pulse),
    .ovf_hi_pulse(ovf_hi_pulse), .ctrl(ctrl_q), .cnt16(cnt16), .rld16(rld16)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/100ps
module reload_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, ovf_lo_pulse, ovf_hi_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lo_pulses = 0;
    int hi_pulses = 0;
    logic clr_pulses = 1'b0;

    reload_timer uut (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ovf_lo_pulse(ovf_lo_pulse), .ovf_hi_pulse(ovf_hi_pulse)
    );

    always #2 clk = ~clk;               // 250 MHz
    initial begin
        #1;
        forever #12 ext_clk = ~ext_clk; // one edge every six clk cycles
    end

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (clr_pulses) begin
            lo_pulses <= 0;
            hi_pulses <= 0;
        end else begin
            if (ovf_lo_pulse) lo_pulses <= lo_pulses + 1;
            if (ovf_hi_pulse) hi_pulses <= hi_pulses + 1;
        end
    end

    typedef struct packed {
        logic [3:0]  req;
        logic        split;
        logic [15:0] rld;
        logic [15:0] start;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic        exp_fl;
        logic        exp_fh;
        logic [3:0]  exp_lop;
        logic [3:0]  exp_hip;
    } vec_t;

    // R2 plain count, R3 16-bit wrap, R4 low wrap, R5 split reloads
    localparam vec_t VECS [6] = '{
        '{4'd2, 1'b0, 16'h1234, 16'h0010, 8'd5, 16'h0015, 1'b0, 1'b0, 4'd0, 4'd0},
        '{4'd3, 1'b0, 16'hABCD, 16'hFFFE, 8'd3, 16'hABCE, 1'b1, 1'b1, 4'd1, 4'd1},
        '{4'd4, 1'b0, 16'h0000, 16'h00FE, 8'd3, 16'h0101, 1'b1, 1'b0, 4'd1, 4'd0},
        '{4'd5, 1'b1, 16'h20F0, 16'hFEFD, 8'd4, 16'h22F1, 1'b1, 1'b1, 4'd1, 4'd1},
        '{4'd5, 1'b1, 16'h8040, 16'h10FF, 8'd1, 16'h1140, 1'b1, 1'b0, 4'd1, 4'd0},
        '{4'd3, 1'b0, 16'hFFFF, 16'hFFFF, 8'd3, 16'hFFFF, 1'b1, 1'b1, 4'd3, 4'd3}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.2 d = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] l, h;
        rd(3'd1, l);
        rd(3'd2, h);
        v = {h, l};
    endtask

    function automatic logic [7:0] cb(input logic [1:0] src, input logic ie,
                                       input logic le, input logic sp, input logic run);
        return {2'b00, src, ie, le, sp, run};
    endfunction

    task automatic load_state(input logic sp, input logic [15:0] rl, input logic [15:0] st);
        wr(3'd0, 8'hC0 | cb(2'd0, 1'b0, 1'b0, sp, 1'b0));
        wr(3'd3, rl[7:0]);
        wr(3'd4, rl[15:8]);
        wr(3'd1, st[7:0]);
        wr(3'd2, st[15:8]);
    endtask

    // start with run=1, then stop so exactly n ticks are taken at source 0
    task automatic run_ticks(input logic sp, input logic [1:0] src, input int n);
        wr(3'd0, cb(src, 1'b0, 1'b0, sp, 1'b1));
        if (n > 1) repeat (n - 1) @(posedge clk);
        wr(3'd0, cb(src, 1'b0, 1'b0, sp, 1'b0));
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), b);
            chk("R1 reg", {8'h0, b}, 16'h0);
        end
        chk("R1 outputs", {13'h0, irq, ovf_lo_pulse, ovf_hi_pulse}, 16'h0);

        // vector table
        foreach (VECS[i]) begin
            load_state(VECS[i].split, VECS[i].rld, VECS[i].start);
            clr_pulses = 1'b1;
            @(posedge clk); #1 clr_pulses = 1'b0;
            run_ticks(VECS[i].split, 2'd0, int'(VECS[i].ticks));
            rd16(v);
            chk($sformatf("R%0d count vec%0d", VECS[i].req, i), v, VECS[i].exp_cnt);
            rd(3'd0, b);
            chk($sformatf("R%0d flags vec%0d", VECS[i].req, i), {14'h0, b[7:6]},
                {14'h0, VECS[i].exp_fh, VECS[i].exp_fl});
            chk($sformatf("R%0d lo pulses vec%0d", VECS[i].req, i), 16'(lo_pulses),
                {12'h0, VECS[i].exp_lop});
            chk($sformatf("R%0d hi pulses vec%0d", VECS[i].req, i), 16'(hi_pulses),
                {12'h0, VECS[i].exp_hip});

            if (i == 0) begin
                // R2: stopped count holds
                repeat (10) @(posedge clk);
                #1 rd16(v);
                chk("R2 hold", v, 16'h0015);
            end
            if (i == 1) begin
                // R7: write-one-to-clear, zero bits leave flags alone
                wr(3'd0, 8'h40);
                #1 rd(3'd0, b);
                chk("R7 clear lo only", {14'h0, b[7:6]}, 16'h2);
                wr(3'd0, 8'h80);
                #1 rd(3'd0, b);
                chk("R7 clear hi", {14'h0, b[7:6]}, 16'h0);
            end
            if (i == 2) begin
                // R6: low flag set, high flag clear (R4 flag set with enable off)
                wr(3'd0, cb(2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
                #1 chk("R6 lo flag masked", {15'h0, irq}, 16'h0);
                wr(3'd0, cb(2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
                #1 chk("R6 lo flag enabled", {15'h0, irq}, 16'h1);
                wr(3'd0, cb(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
                #1 chk("R6 master off", {15'h0, irq}, 16'h0);
            end
            if (i == 5) begin
                // R6: high flag alone raises irq
                wr(3'd0, cb(2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
                #1 chk("R6 hi flag", {15'h0, irq}, 16'h1);
            end
        end

        // R8: bus write to low byte at the 16-bit wrap edge
        load_state(1'b0, 16'h1234, 16'hFFFF);
        wr(3'd0, cb(2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(3'd1, 8'h55);
        wr(3'd0, cb(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        #1 rd16(v);
        chk("R8 write priority", v, 16'h1256);
        rd(3'd0, b);
        chk("R8 hi flag still set", {15'h0, b[7]}, 16'h1);

        // R9: divide-by-12 source over 36 cycles
        load_state(1'b0, 16'h0000, 16'h0000);
        run_ticks(1'b0, 2'd1, 36);
        rd16(v);
        chk("R9 div12", v, 16'h0003);

        // R10: external source over 384 cycles (64 edges)
        load_state(1'b0, 16'h0000, 16'h0000);
        run_ticks(1'b0, 2'd2, 384);
        rd16(v);
        chk("R10 ext div8", v, 16'h0008);

        // R10: source 3 never ticks
        load_state(1'b0, 16'h0000, 16'h0042);
        run_ticks(1'b0, 2'd3, 50);
        rd16(v);
        chk("R10 no source", v, 16'h0042);

        // R11: reload readback and unused address
        rd(3'd3, b);
        chk("R11 reload lo", {8'h0, b}, 16'h0000);
        wr(3'd4, 8'h9A);
        #1 rd(3'd4, b);
        chk("R11 reload hi", {8'h0, b}, 16'h009A);
        rd(3'd5, b);
        chk("R11 unused", {8'h0, b}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule